// File: doc/BRIEF.md
# Indexed-Colour Display Register File

This block is the control register file of an 8-bit indexed-colour display controller. A host reaches it through a simple 32-bit address/data request bus. Every access is a full word, and a response comes back on the cycle after each request. The block holds the following state:

- the main colour lookup table
- a small colour table for the pointer overlay
- the pointer bitmap
- the geometry, control, frame-base and pointer-position registers

Scan-out and pointer logic read the tables through registered lookup ports. They take the decoded mode bits, the geometry and the pointer position straight from the outputs.

Writes to the horizontal and vertical display registers are stored in pixel and line units, and reads convert back. A write to one dedicated offset clears all state, and several legacy timing offsets accept writes and discard them. A frame-complete pulse from scan-out raises an interrupt line, and any host write lowers it.

Top module: `dispctl_regfile`

## Requirements
- R1: Each request sampled with `req_valid` high produces `rsp_valid` high for exactly the next cycle. `rsp_rdata` is valid in that same cycle, and it is zero for writes.
- R2: A write to byte offset 0x800 + 8*i (i = 0..255, index taken from address bits 10:3) stores red from data bits 23:16, green from 15:8 and blue from 7:0. `pix_index` = i returns {red,green,blue} on `pix_rgb` one cycle later. Bus reads in this range return zero.
- R3: Offsets 0x508, 0x510 and 0x518 hold pointer colours 0, 1 and 2, packed the same way as in R2. Reads return the 24-bit colour zero-extended. `cur_sel` 0..2 returns that colour one cycle later, and `cur_sel` = 3 returns zero.
- R4: Offset 0x1000 + 8*k (k = 0..511) stores data bits 15:0 as pointer bitmap word k. Reads return the word zero-extended, and `pat_addr` = k returns it on `pat_word` one cycle later.
- R5: A write of v to offset 0x118 sets `disp_width` to (v*4) truncated to 14 bits. A read returns `disp_width`/4.
- R6: A write of v to offset 0x150 sets `disp_height` to v[12:1]. A read returns `disp_height`*2.
- R7: Offset 0x300 reads back the last word written to it. Its bits 22:20 drive `pixel_bpp` as follows: 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, and 6 or 7→0. Bit 10 drives `force_blank`, and when bit 23 is set, `cursor_en` is low.
- R8: Offset 0x400 drives `top_addr`. Offset 0x638 drives `cursor_x` from data bits 23:12 and `cursor_y` from bits 11:0. Both offsets read as zero.
- R9: Writes to offsets 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no output and no readable register.
- R10: A read from any offset not listed as readable above returns zero.
- R11: A write to offset 0x100000 clears every table entry, every register and the interrupt in one cycle.
- R12: A `frame_done` pulse sets `frame_irq` from the next cycle. Any write clears it from the next cycle. When both occur in the same cycle, the interrupt is set.
- R13: After `rst_n` is released, all tables, registers, `frame_irq` and `rsp_valid` are zero, and `cursor_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| frame_done | input | 1 | Frame-complete pulse from scan-out |
| frame_irq | output | 1 | Frame interrupt |
| pix_index | input | 8 | Colour table lookup index |
| pix_rgb | output | 24 | Colour table lookup result |
| cur_sel | input | 2 | Pointer colour select |
| cur_rgb | output | 24 | Pointer colour result |
| pat_addr | input | 9 | Pointer bitmap word address |
| pat_word | output | 16 | Pointer bitmap word |
| disp_width | output | 14 | Active width in pixels |
| disp_height | output | 12 | Active height in lines |
| top_addr | output | 32 | Frame base offset |
| cursor_x | output | 12 | Pointer column |
| cursor_y | output | 12 | Pointer row |
| cursor_en | output | 1 | Pointer overlay enabled |
| force_blank | output | 1 | Blank the display |
| pixel_bpp | output | 5 | Decoded bits per pixel, 0 = invalid |

## Verification
The embedded properties watch four things on every cycle: the one-cycle response, zero read data on writes, interrupt set and clear priority, and the one-cycle clearing done by the reset offset. The bench scenarios are the only place that shows the data side. That covers RGB field packing, the width and height scaling in both directions, the depth code table, pointer position splitting, and the lookup ports after their register stage. Silence of the timing offsets and zero reads of write-only or unmapped offsets also need scenarios, because they show up only when state is read back after the stimulus.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_CPAL,
      RG_PPAL,
      RG_PBMP,
      RG_HDISP,
      RG_VDISP,
      RG_CTRL,
      RG_TOP,
      RG_CPOS,
      RG_CLEAR,
      RG_TIMING
   } region_t;

   localparam logic [31:0] OFS_CPAL  = 32'h0000_0800;
   localparam logic [31:0] OFS_PPAL  = 32'h0000_0508;
   localparam logic [31:0] OFS_PBMP  = 32'h0000_1000;
   localparam logic [31:0] OFS_HDISP = 32'h0000_0118;
   localparam logic [31:0] OFS_VDISP = 32'h0000_0150;
   localparam logic [31:0] OFS_CTRL  = 32'h0000_0300;
   localparam logic [31:0] OFS_TOP   = 32'h0000_0400;
   localparam logic [31:0] OFS_CPOS  = 32'h0000_0638;
   localparam logic [31:0] OFS_CLEAR = 32'h0010_0000;
   localparam int unsigned STRIDE_SH = 3;

   localparam int unsigned CTRL_BLANK_BIT = 10;
   localparam int unsigned CTRL_NOCUR_BIT = 23;
   localparam int unsigned CTRL_DEPTH_LO  = 20;

   function automatic logic [4:0] depth_to_bpp(input logic [2:0] code);
      case (code)
         3'd0:    return 5'd1;
         3'd1:    return 5'd2;
         3'd2:    return 5'd4;
         3'd3:    return 5'd8;
         3'd4:    return 5'd15;
         3'd5:    return 5'd16;
         default: return 5'd0;
      endcase
   endfunction

   function automatic logic is_timing_ofs(input logic [31:0] a);
      case (a)
         32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
         32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200:
            return 1'b1;
         default:
            return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dispctl_decode.sv
module dispctl_decode
   import dispctl_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int PAL_DEPTH  = 256,
   parameter int PPAL_DEPTH = 3,
   parameter int PBMP_DEPTH = 512,
   parameter int IDX_W      = 9
) (
   input  logic [ADDR_W-1:0] addr,
   output region_t           region,
   output logic [IDX_W-1:0]  idx
);

   localparam logic [31:0] CPAL_END = OFS_CPAL + 32'(PAL_DEPTH  << STRIDE_SH);
   localparam logic [31:0] PPAL_END = OFS_PPAL + 32'(PPAL_DEPTH << STRIDE_SH);
   localparam logic [31:0] PBMP_END = OFS_PBMP + 32'(PBMP_DEPTH << STRIDE_SH);

   logic [31:0] a32;
   logic [31:0] off;

   assign a32 = 32'(addr);

   always_comb begin
      region = RG_NONE;
      off    = '0;
      if (a32 >= OFS_CPAL && a32 < CPAL_END) begin
         region = RG_CPAL;
         off    = a32 - OFS_CPAL;
      end else if (a32 >= OFS_PBMP && a32 < PBMP_END) begin
         region = RG_PBMP;
         off    = a32 - OFS_PBMP;
      end else if (a32 >= OFS_PPAL && a32 < PPAL_END) begin
         region = RG_PPAL;
         off    = a32 - OFS_PPAL;
      end else if (a32 == OFS_HDISP) begin
         region = RG_HDISP;
      end else if (a32 == OFS_VDISP) begin
         region = RG_VDISP;
      end else if (a32 == OFS_CTRL) begin
         region = RG_CTRL;
      end else if (a32 == OFS_TOP) begin
         region = RG_TOP;
      end else if (a32 == OFS_CPOS) begin
         region = RG_CPOS;
      end else if (a32 == OFS_CLEAR) begin
         region = RG_CLEAR;
      end else if (is_timing_ofs(a32)) begin
         region = RG_TIMING;
      end
   end

   assign idx = IDX_W'(off >> STRIDE_SH);

endmodule

// File: rtl/dispctl_bank.sv
module dispctl_bank #(
   parameter int DEPTH      = 256,
   parameter int DATA_W     = 24,
   parameter bit LOOKUP_REG = 1'b1,
   localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   input  logic [AW-1:0]     laddr,
   output logic [DATA_W-1:0] ldata
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dispctl_bank: DEPTH must be at least 2");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("dispctl_bank: DATA_W must be 1..32");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] lk_comb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (clr)
               mem[e] <= '0;
            else if (we && waddr == AW'(e))
               mem[e] <= wdata;
         end
      end
   end

   assign rdata   = (32'(raddr) < DEPTH) ? mem[raddr] : '0;
   assign lk_comb = (32'(laddr) < DEPTH) ? mem[laddr] : '0;

   if (LOOKUP_REG) begin : g_lookup_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ldata <= '0;
         else        ldata <= lk_comb;
      end
   end else begin : g_lookup_comb
      assign ldata = lk_comb;
   end

   // R11
   bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rdata == '0))
      else $error("bank clear left data behind");

endmodule

// File: rtl/dispctl_ctrl.sv
module dispctl_ctrl
   import dispctl_pkg::*;
#(
   parameter int WIDTH_W  = 14,
   parameter int HEIGHT_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  region_t             region,
   input  logic [31:0]         wdata,
   input  logic                frame_done,
   output logic [WIDTH_W-1:0]  width_q,
   output logic [HEIGHT_W-1:0] height_q,
   output logic [31:0]         ctrl_q,
   output logic [31:0]         top_q,
   output logic [23:0]         cpos_q,
   output logic                irq_q
);

   logic clr;
   assign clr = wr_en && (region == RG_CLEAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q  <= '0;
         height_q <= '0;
         ctrl_q   <= '0;
         top_q    <= '0;
         cpos_q   <= '0;
      end else if (clr) begin
         width_q  <= '0;
         height_q <= '0;
         ctrl_q   <= '0;
         top_q    <= '0;
         cpos_q   <= '0;
      end else if (wr_en) begin
         case (region)
            RG_HDISP: width_q  <= {wdata[WIDTH_W-3:0], 2'b00};
            RG_VDISP: height_q <= wdata[HEIGHT_W:1];
            RG_CTRL:  ctrl_q   <= wdata;
            RG_TOP:   top_q    <= wdata;
            RG_CPOS:  cpos_q   <= wdata[23:0];
            default:  ;
         endcase
      end
   end

   // frame completion wins over a same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          irq_q <= 1'b0;
      else if (frame_done) irq_q <= 1'b1;
      else if (wr_en)      irq_q <= 1'b0;
   end

   // R12
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> irq_q)
      else $error("interrupt not raised after frame");

   // R12
   irq_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !frame_done) |=> !irq_q)
      else $error("interrupt not lowered by write");

   // R11
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (width_q == '0 && height_q == '0 && ctrl_q == '0 &&
               top_q == '0 && cpos_q == '0))
      else $error("clear offset left registers set");

endmodule

// File: rtl/dispctl_regfile.sv
module dispctl_regfile
   import dispctl_pkg::*;
#(
   parameter int ADDR_W       = 21,
   parameter int PAL_DEPTH    = 256,
   parameter int PPAL_DEPTH   = 3,
   parameter int PBMP_DEPTH   = 512,
   parameter int RGB_W        = 24,
   parameter int PBMP_W       = 16,
   parameter int WIDTH_W      = 14,
   parameter int HEIGHT_W     = 12,
   parameter bit PAL_READABLE = 1'b0,
   localparam int PAL_AW      = $clog2(PAL_DEPTH),
   localparam int PPAL_AW     = $clog2(PPAL_DEPTH),
   localparam int PBMP_AW     = $clog2(PBMP_DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [31:0]         req_wdata,
   output logic                rsp_valid,
   output logic [31:0]         rsp_rdata,
   input  logic                frame_done,
   output logic                frame_irq,
   input  logic [PAL_AW-1:0]   pix_index,
   output logic [RGB_W-1:0]    pix_rgb,
   input  logic [PPAL_AW-1:0]  cur_sel,
   output logic [RGB_W-1:0]    cur_rgb,
   input  logic [PBMP_AW-1:0]  pat_addr,
   output logic [PBMP_W-1:0]   pat_word,
   output logic [WIDTH_W-1:0]  disp_width,
   output logic [HEIGHT_W-1:0] disp_height,
   output logic [31:0]         top_addr,
   output logic [11:0]         cursor_x,
   output logic [11:0]         cursor_y,
   output logic                cursor_en,
   output logic                force_blank,
   output logic [4:0]          pixel_bpp
);

   localparam int IDX_W_A = (PAL_AW > PPAL_AW) ? PAL_AW : PPAL_AW;
   localparam int IDX_W   = (IDX_W_A > PBMP_AW) ? IDX_W_A : PBMP_AW;

   if (ADDR_W < 21 || ADDR_W > 32) begin : g_bad_addr
      $error("dispctl_regfile: ADDR_W must be 21..32");
   end
   if (WIDTH_W < 3 || WIDTH_W > 34) begin : g_bad_wid
      $error("dispctl_regfile: WIDTH_W must be 3..34");
   end
   if (HEIGHT_W < 1 || HEIGHT_W > 30) begin : g_bad_hgt
      $error("dispctl_regfile: HEIGHT_W must be 1..30");
   end
   if (OFS_CPAL + (PAL_DEPTH << STRIDE_SH) > OFS_PBMP) begin : g_bad_pal
      $error("dispctl_regfile: colour table overlaps bitmap window");
   end
   if (RGB_W != 24 || PBMP_W > 32) begin : g_bad_data
      $error("dispctl_regfile: unsupported data widths");
   end

   region_t          dec_region;
   logic [IDX_W-1:0] dec_idx;
   logic             wr_en;
   logic             clr;

   dispctl_decode #(
      .ADDR_W     (ADDR_W),
      .PAL_DEPTH  (PAL_DEPTH),
      .PPAL_DEPTH (PPAL_DEPTH),
      .PBMP_DEPTH (PBMP_DEPTH),
      .IDX_W      (IDX_W)
   ) u_decode (
      .addr   (req_addr),
      .region (dec_region),
      .idx    (dec_idx)
   );

   assign wr_en = req_valid && req_write;
   assign clr   = wr_en && (dec_region == RG_CLEAR);

   logic [RGB_W-1:0]  cpal_rd;
   logic [RGB_W-1:0]  ppal_rd;
   logic [PBMP_W-1:0] pbmp_rd;

   dispctl_bank #(.DEPTH(PAL_DEPTH), .DATA_W(RGB_W), .LOOKUP_REG(1'b1)) u_cpal (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .we    (wr_en && dec_region == RG_CPAL),
      .waddr (dec_idx[PAL_AW-1:0]),
      .wdata (req_wdata[RGB_W-1:0]),
      .raddr (dec_idx[PAL_AW-1:0]),
      .rdata (cpal_rd),
      .laddr (pix_index),
      .ldata (pix_rgb)
   );

   dispctl_bank #(.DEPTH(PPAL_DEPTH), .DATA_W(RGB_W), .LOOKUP_REG(1'b1)) u_ppal (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .we    (wr_en && dec_region == RG_PPAL),
      .waddr (dec_idx[PPAL_AW-1:0]),
      .wdata (req_wdata[RGB_W-1:0]),
      .raddr (dec_idx[PPAL_AW-1:0]),
      .rdata (ppal_rd),
      .laddr (cur_sel),
      .ldata (cur_rgb)
   );

   dispctl_bank #(.DEPTH(PBMP_DEPTH), .DATA_W(PBMP_W), .LOOKUP_REG(1'b1)) u_pbmp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .we    (wr_en && dec_region == RG_PBMP),
      .waddr (dec_idx[PBMP_AW-1:0]),
      .wdata (req_wdata[PBMP_W-1:0]),
      .raddr (dec_idx[PBMP_AW-1:0]),
      .rdata (pbmp_rd),
      .laddr (pat_addr),
      .ldata (pat_word)
   );

   logic [WIDTH_W-1:0]  width_q;
   logic [HEIGHT_W-1:0] height_q;
   logic [31:0]         ctrl_q;
   logic [31:0]         top_q;
   logic [23:0]         cpos_q;

   dispctl_ctrl #(.WIDTH_W(WIDTH_W), .HEIGHT_W(HEIGHT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .region     (dec_region),
      .wdata      (req_wdata),
      .frame_done (frame_done),
      .width_q    (width_q),
      .height_q   (height_q),
      .ctrl_q     (ctrl_q),
      .top_q      (top_q),
      .cpos_q     (cpos_q),
      .irq_q      (frame_irq)
   );

   assign disp_width  = width_q;
   assign disp_height = height_q;
   assign top_addr    = top_q;
   assign cursor_x    = cpos_q[23:12];
   assign cursor_y    = cpos_q[11:0];
   assign cursor_en   = ~ctrl_q[CTRL_NOCUR_BIT];
   assign force_blank = ctrl_q[CTRL_BLANK_BIT];
   assign pixel_bpp   = depth_to_bpp(ctrl_q[CTRL_DEPTH_LO +: 3]);

   logic [31:0] rd_mux;

   always_comb begin
      case (dec_region)
         RG_CPAL:  rd_mux = PAL_READABLE ? 32'(cpal_rd) : 32'd0;
         RG_PPAL:  rd_mux = 32'(ppal_rd);
         RG_PBMP:  rd_mux = 32'(pbmp_rd);
         RG_HDISP: rd_mux = 32'(width_q[WIDTH_W-1:2]);
         RG_VDISP: rd_mux = 32'({height_q, 1'b0});
         RG_CTRL:  rd_mux = ctrl_q;
         default:  rd_mux = 32'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= (req_valid && !req_write) ? rd_mux : 32'd0;
      end
   end

   // R1
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid)
      else $error("request not acknowledged");

   // R1
   rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid)
      else $error("response without request");

   // R1
   wr_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == 32'd0))
      else $error("write returned data");

endmodule

// File: tb/dispctl_regfile_test.sv
module dispctl_regfile_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [20:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        frame_done = 1'b0;
   logic        frame_irq;
   logic [7:0]  pix_index = '0;
   logic [23:0] pix_rgb;
   logic [1:0]  cur_sel = '0;
   logic [23:0] cur_rgb;
   logic [8:0]  pat_addr = '0;
   logic [15:0] pat_word;
   logic [13:0] disp_width;
   logic [11:0] disp_height;
   logic [31:0] top_addr;
   logic [11:0] cursor_x;
   logic [11:0] cursor_y;
   logic        cursor_en;
   logic        force_blank;
   logic [4:0]  pixel_bpp;

   always #5 clk = ~clk;

   dispctl_regfile uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .frame_done(frame_done), .frame_irq(frame_irq),
      .pix_index(pix_index), .pix_rgb(pix_rgb),
      .cur_sel(cur_sel), .cur_rgb(cur_rgb),
      .pat_addr(pat_addr), .pat_word(pat_word),
      .disp_width(disp_width), .disp_height(disp_height), .top_addr(top_addr),
      .cursor_x(cursor_x), .cursor_y(cursor_y), .cursor_en(cursor_en),
      .force_blank(force_blank), .pixel_bpp(pixel_bpp)
   );

   typedef struct {
      bit          is_rd;
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops one expectation per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk("R1 unexpected response", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.is_rd) chk(e.tag, rsp_rdata, e.exp);
            else         chk("R1 write rdata", rsp_rdata, 32'd0);
         end
      end
   end

   task automatic wr(input logic [20:0] a, input logic [31:0] d);
      exp_t e;
      e.is_rd = 1'b0; e.exp = '0; e.tag = "";
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [20:0] a, input logic [31:0] x, input string tag);
      exp_t e;
      e.is_rd = 1'b1; e.exp = x; e.tag = tag;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic look(input logic [7:0] pi, input logic [1:0] cs, input logic [8:0] pa);
      @(negedge clk);
      pix_index = pi; cur_sel = cs; pat_addr = pa;
      @(negedge clk);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13 irq", 32'(frame_irq), 32'd0);
      chk("R13 rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R13 width", 32'(disp_width), 32'd0);
      chk("R13 cursor_en", 32'(cursor_en), 32'd1);
      chk("R13 bpp", 32'(pixel_bpp), 32'd1);
      look(8'd0, 2'd0, 9'd0);
      chk("R13 pix", 32'(pix_rgb), 32'd0);
      rd(21'h118, 32'd0, "R13 width read");

      // R1 response lasts one cycle
      wr(21'h004, 32'h1);
      chk("R1 single cycle", 32'(rsp_valid), 32'd1);
      @(negedge clk);
      chk("R1 drop", 32'(rsp_valid), 32'd0);

      // R2 colour table
      wr(21'h828, 32'h00AABBCC);
      wr(21'hFF8, 32'hFF123456);
      look(8'd5, 2'd0, 9'd0);
      chk("R2 pix 5", 32'(pix_rgb), 32'h00AABBCC);
      look(8'd255, 2'd0, 9'd0);
      chk("R2 pix 255", 32'(pix_rgb), 32'h00123456);
      rd(21'h828, 32'd0, "R2 table read zero");

      // R3 pointer colours
      wr(21'h510, 32'h00112233);
      wr(21'h518, 32'hAB445566);
      rd(21'h510, 32'h00112233, "R3 read 1");
      rd(21'h518, 32'h00445566, "R3 read 2");
      rd(21'h508, 32'h0, "R3 read 0");
      look(8'd0, 2'd1, 9'd0);
      chk("R3 sel 1", 32'(cur_rgb), 32'h00112233);
      look(8'd0, 2'd3, 9'd0);
      chk("R3 sel 3", 32'(cur_rgb), 32'h0);

      // R4 pointer bitmap
      wr(21'h1FF8, 32'hDEADBEEF);
      wr(21'h1008, 32'h00001357);
      rd(21'h1FF8, 32'h0000BEEF, "R4 read 511");
      rd(21'h1008, 32'h00001357, "R4 read 1");
      look(8'd0, 2'd0, 9'd511);
      chk("R4 lookup 511", 32'(pat_word), 32'h0000BEEF);

      // R5 width
      wr(21'h118, 32'h12340140);
      chk("R5 width", 32'(disp_width), 32'h500);
      rd(21'h118, 32'h140, "R5 read");
      wr(21'h118, 32'h00000FFF);
      chk("R5 width max", 32'(disp_width), 32'h3FFC);
      rd(21'h118, 32'hFFF, "R5 read max");

      // R6 height
      wr(21'h150, 32'h00000301);
      chk("R6 height", 32'(disp_height), 32'h180);
      rd(21'h150, 32'h300, "R6 read");

      // R7 control
      wr(21'h300, 32'h00B00400);
      chk("R7 bpp 8", 32'(pixel_bpp), 32'd8);
      chk("R7 blank", 32'(force_blank), 32'd1);
      chk("R7 cursor off", 32'(cursor_en), 32'd0);
      rd(21'h300, 32'h00B00400, "R7 read");
      wr(21'h300, 32'h00400000);
      chk("R7 bpp 15", 32'(pixel_bpp), 32'd15);
      wr(21'h300, 32'h00600000);
      chk("R7 bpp invalid", 32'(pixel_bpp), 32'd0);
      wr(21'h300, 32'h00500000);
      chk("R7 bpp 16", 32'(pixel_bpp), 32'd16);
      chk("R7 blank off", 32'(force_blank), 32'd0);
      chk("R7 cursor on", 32'(cursor_en), 32'd1);

      // R8 frame base and pointer position
      wr(21'h400, 32'h00123000);
      chk("R8 top", top_addr, 32'h00123000);
      wr(21'h638, 32'h00ABC123);
      chk("R8 x", 32'(cursor_x), 32'hABC);
      chk("R8 y", 32'(cursor_y), 32'h123);
      rd(21'h400, 32'h0, "R8 top read");
      rd(21'h638, 32'h0, "R8 pos read");

      // R9 timing offsets silent
      wr(21'h110, 32'hFFFFFFFF);
      wr(21'h200, 32'hFFFFFFFF);
      wr(21'h000, 32'hFFFFFFFF);
      wr(21'h170, 32'hFFFFFFFF);
      chk("R9 width", 32'(disp_width), 32'h180 * 0 + 32'h3FFC);
      chk("R9 height", 32'(disp_height), 32'h180);
      chk("R9 bpp", 32'(pixel_bpp), 32'd16);
      chk("R9 top", top_addr, 32'h00123000);
      chk("R9 x", 32'(cursor_x), 32'hABC);
      rd(21'h300, 32'h00500000, "R9 ctrl read");

      // R10 unmapped reads
      rd(21'h004, 32'h0, "R10 read 004");
      rd(21'h000, 32'h0, "R10 read 000");
      rd(21'h520, 32'h0, "R10 read 520");

      // R12 interrupt
      @(negedge clk); frame_done = 1'b1;
      @(negedge clk); frame_done = 1'b0;
      chk("R12 raise", 32'(frame_irq), 32'd1);
      wr(21'h110, 32'h0);
      chk("R12 lower", 32'(frame_irq), 32'd0);
      begin
         exp_t e;
         e.is_rd = 1'b0; e.exp = '0; e.tag = "";
         @(negedge clk);
         frame_done = 1'b1;
         req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h004; req_wdata = 32'h0;
         exp_q.push_back(e);
         @(negedge clk);
         frame_done = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      end
      chk("R12 set wins", 32'(frame_irq), 32'd1);

      // R11 clear offset
      wr(21'h100000, 32'h0);
      chk("R11 irq", 32'(frame_irq), 32'd0);
      chk("R11 width", 32'(disp_width), 32'd0);
      chk("R11 top", top_addr, 32'd0);
      chk("R11 cursor_en", 32'(cursor_en), 32'd1);
      look(8'd5, 2'd1, 9'd511);
      chk("R11 pix", 32'(pix_rgb), 32'd0);
      chk("R11 cur", 32'(cur_rgb), 32'd0);
      chk("R11 pat", 32'(pat_word), 32'd0);
      rd(21'h510, 32'h0, "R11 ppal read");
      rd(21'h150, 32'h0, "R11 height read");

      repeat (2) @(negedge clk);
      chk("R1 all answered", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      summary();
   end

endmodule